// File: doc/BRIEF.md
# Fetch Address Select and Next-PC Prediction

This block sits in the fetch stage of a five-stage in-order pipeline. Each cycle it chooses the address from which the instruction memory is read, and it computes a guess for the address of the instruction that follows the one now being fetched. That guess is kept in a small register and becomes the default fetch address of the next cycle.

The fetch address is normally the stored guess. Two later stages can override it.

- The memory stage can override it when it holds a conditional jump that turned out not to be taken. Jumps are always guessed taken, so this is a misprediction. The correct sequential address travels down the pipe with the jump.
- The write-back stage can override it when it holds a return instruction. The true return address is then known there, because it has been loaded from memory.

The guess itself uses a fixed rule based on the instruction class:

- Jumps and calls guess their constant field, which is the target address.
- Every other instruction guesses the sequential address.

A stall input freezes the stored guess while the front of the pipeline is held.

Top module: `fetch_pc_select`

## Requirements
- R1: While reset is asserted, and right after it is released, the stored guess `pred_pc` is address 0.
- R2: When `mem_code` equals the jump code (default 4'h7) and `mem_taken` is 0, `fetch_pc` equals `mem_seq_pc`.
- R3: When there is no misprediction as in R2 and `wb_code` equals the return code (default 4'h9), `fetch_pc` equals `wb_loaded`.
- R4: When neither R2 nor R3 applies, `fetch_pc` equals `pred_pc`.
- R5: When a misprediction (R2) and a completing return (R3) occur in the same cycle, `fetch_pc` takes `mem_seq_pc`.
- R6: With `stall` low and `f_code` equal to the jump code, `pred_pc` after the next rising edge equals `f_const`. This is the taken guess.
- R7: With `stall` low and `f_code` equal to the call code (default 4'h8), `pred_pc` after the next rising edge equals `f_const`.
- R8: With `stall` low and any other `f_code`, including the return code, `pred_pc` after the next rising edge equals `f_seq_pc`.
- R9: While `stall` is high, `pred_pc` keeps its value across rising edges.
- R10: Neither of the following changes `fetch_pc` from `pred_pc`:
  - a jump in the memory stage with `mem_taken` 1;
  - a non-jump code in the memory stage with `mem_taken` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Holds the stored guess when high |
| f_code | input | 4 | Instruction code of the instruction in fetch |
| f_const | input | 32 | Constant (target) field of the instruction in fetch |
| f_seq_pc | input | 32 | Address following the instruction in fetch |
| mem_code | input | 4 | Instruction code held in the memory-stage register |
| mem_taken | input | 1 | Branch outcome of the memory-stage instruction |
| mem_seq_pc | input | 32 | Fall-through address carried by the memory-stage jump |
| wb_code | input | 4 | Instruction code held in the write-back register |
| wb_loaded | input | 32 | Value loaded from memory, carried in write-back |
| fetch_pc | output | 32 | Address to fetch this cycle |
| pred_pc | output | 32 | Stored guess for the next fetch address |

## Verification
The two overrides can fall in the same cycle. This happens when an untaken conditional jump reaches the memory stage while an older return completes in write-back. The bench provokes this by driving a jump with a false branch flag and a return code with distinct address values together. It judges the result by requiring `fetch_pc` to equal the jump's fall-through address rather than the loaded return address. Neighbouring vectors present each override alone, and also near-misses: a taken jump, and a non-return code in write-back. These confirm that only the exact conditions redirect fetch.

// File: rtl/fetch_pc_select.sv
module fetch_pc_select #(
  parameter int          AW        = 32,
  parameter int          CW        = 4,
  parameter logic [CW-1:0] CODE_JMP  = 4'h7,
  parameter logic [CW-1:0] CODE_CALL = 4'h8,
  parameter logic [CW-1:0] CODE_RET  = 4'h9,
  parameter logic [AW-1:0] RESET_PC  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [CW-1:0] f_code,
  input  logic [AW-1:0] f_const,
  input  logic [AW-1:0] f_seq_pc,
  input  logic [CW-1:0] mem_code,
  input  logic          mem_taken,
  input  logic [AW-1:0] mem_seq_pc,
  input  logic [CW-1:0] wb_code,
  input  logic [AW-1:0] wb_loaded,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] pred_pc
);

  logic          mispredict;
  logic          ret_done;
  logic          to_target;
  logic [AW-1:0] next_guess;

  assign mispredict = (mem_code == CODE_JMP) && !mem_taken;
  assign ret_done   = (wb_code == CODE_RET);
  assign fetch_pc   = mispredict ? mem_seq_pc :
                      ret_done   ? wb_loaded  : pred_pc;

  assign to_target  = (f_code == CODE_JMP) || (f_code == CODE_CALL);
  assign next_guess = to_target ? f_const : f_seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pred_pc <= RESET_PC;
    else if (!stall) pred_pc <= next_guess;
  end

  AST_JMP_GUESS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && f_code == CODE_JMP) |=> pred_pc == $past(f_const)); // R6
  AST_CALL_GUESS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && f_code == CODE_CALL) |=> pred_pc == $past(f_const)); // R7
  AST_OTHER_GUESS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && f_code != CODE_JMP && f_code != CODE_CALL) |=> pred_pc == $past(f_seq_pc)); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pred_pc)); // R9
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> pred_pc == RESET_PC); // R1
  AST_QUIET_USES_GUESS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_code != CODE_JMP && wb_code != CODE_RET) |-> fetch_pc == pred_pc); // R4

endmodule

// File: tb/tb_fetch_pc_select.sv
module tb_fetch_pc_select;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        stall = 0;
  logic [3:0]  f_code = 0, mem_code = 0, wb_code = 0;
  logic        mem_taken = 0;
  logic [31:0] f_const = 0, f_seq_pc = 0, mem_seq_pc = 0, wb_loaded = 0;
  logic [31:0] fetch_pc, pred_pc;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fetch_pc_select dut (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .f_code(f_code), .f_const(f_const), .f_seq_pc(f_seq_pc),
    .mem_code(mem_code), .mem_taken(mem_taken), .mem_seq_pc(mem_seq_pc),
    .wb_code(wb_code), .wb_loaded(wb_loaded),
    .fetch_pc(fetch_pc), .pred_pc(pred_pc)
  );

  typedef struct packed {
    logic        st;
    logic [3:0]  fc;
    logic [31:0] fk;
    logic [31:0] fs;
    logic [3:0]  mc;
    logic        mt;
    logic [31:0] ms;
    logic [3:0]  wc;
    logic [31:0] wl;
    logic [31:0] exp_fetch;
    logic [31:0] exp_pred;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R4 R8: quiet, nop in fetch
    '{1'b0, 4'h0, 32'h0,   32'h10,  4'h0, 1'b0, 32'h0,   4'h0, 32'h0,   32'h0,   32'h10},
    // R6: jump guessed taken
    '{1'b0, 4'h7, 32'h200, 32'h15,  4'h0, 1'b0, 32'h0,   4'h0, 32'h0,   32'h10,  32'h200},
    // R7 R10: call, taken jump in memory does not redirect
    '{1'b0, 4'h8, 32'h300, 32'h205, 4'h7, 1'b1, 32'hAAA, 4'h0, 32'h0,   32'h200, 32'h300},
    // R3 R8: return completes; return in fetch guesses sequential
    '{1'b0, 4'h9, 32'h0,   32'h301, 4'h0, 1'b0, 32'h0,   4'h9, 32'h444, 32'h444, 32'h301},
    // R5: misprediction and return together
    '{1'b0, 4'h0, 32'h0,   32'h556, 4'h7, 1'b0, 32'h555, 4'h9, 32'h666, 32'h555, 32'h556},
    // R2 R9: misprediction alone, stall holds guess
    '{1'b1, 4'h7, 32'h999, 32'h99C, 4'h7, 1'b0, 32'h123, 4'h0, 32'h0,   32'h123, 32'h556},
    // R10: non-jump with false flag does not redirect
    '{1'b0, 4'h8, 32'h800, 32'h55B, 4'h3, 1'b0, 32'h777, 4'h0, 32'h0,   32'h556, 32'h800},
    // R4: non-return code in write-back
    '{1'b0, 4'h1, 32'h0,   32'h804, 4'h0, 1'b0, 32'h0,   4'h7, 32'hBBB, 32'h800, 32'h804}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    stall = v.st; f_code = v.fc; f_const = v.fk; f_seq_pc = v.fs;
    mem_code = v.mc; mem_taken = v.mt; mem_seq_pc = v.ms;
    wb_code = v.wc; wb_loaded = v.wl;
  endtask

  initial begin
    #6;
    check("R1 reset guess", pred_pc, 32'h0);
    check("R1 reset fetch", fetch_pc, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // f_seq_pc is 0 while quiet, guess stays 0
    check("R1 after release", pred_pc, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #2;
      check($sformatf("R2-select vec%0d fetch", i), fetch_pc, VECS[i].exp_fetch);
      @(posedge clk);
      #1;
      check($sformatf("R6-guess vec%0d pred", i), pred_pc, VECS[i].exp_pred);
    end

    // R9: two stalled cycles keep 0x804
    @(negedge clk);
    drive('{1'b1, 4'h7, 32'hF00, 32'hF04, 4'h0, 1'b0, 32'h0, 4'h0, 32'h0, 32'h0, 32'h0});
    repeat (2) @(posedge clk);
    #1;
    check("R9 multi-cycle stall", pred_pc, 32'h804);
    // R5 again with stall released, differing values
    @(negedge clk);
    drive('{1'b0, 4'h0, 32'h0, 32'h40, 4'h7, 1'b0, 32'h1111, 4'h9, 32'h2222, 32'h0, 32'h0});
    #2;
    check("R5 priority", fetch_pc, 32'h1111);
    @(posedge clk);
    #1;
    check("R8 guess", pred_pc, 32'h40);
    // R1: reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R1 mid-run reset", pred_pc, 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule